// File: doc/BRIEF.md
# Constant Coefficient Multiplier with Signed-Digit Recoding

This block multiplies a streaming input word by a coefficient that is fixed when the design is elaborated. No general multiplier array is built. Instead, the coefficient is rewritten at elaboration into digits drawn from {-1, 0, +1}, in the form with no two adjacent nonzero digits. Each nonzero digit becomes one shifted copy of the input, added or subtracted. A balanced tree then sums those copies. A run of ones in the coefficient therefore costs one add and one subtract, not one add per bit.

The input is read as unsigned or as two's complement, set by a parameter. The product is full width: input width plus coefficient width plus one guard bit, so no partial sum can overflow. A parameter selects the output stage. With the register, the product and its valid flag appear one cycle after the input. Without it, the path is purely combinational. Typical use is a fixed filter tap, a scaling stage or a unit conversion inside a larger datapath.

The output stage has two states. The first is *idle*: the valid output is low and the product register holds its last value. The second is *emit*: the valid output is high for the cycle after an input was accepted. The stage moves from idle to emit, or stays in emit, whenever the valid input is high at a clock edge. It moves from emit to idle, or stays in idle, when the valid input is low. Reset forces idle.

Top module: `csdm_mult`

## Requirements
- R1: With the output register present, `out_product` equals `in_data` times `COEF`, reduced to `DATA_W+COEF_W+1` bits. It appears in the cycle after the edge at which `in_valid` was high.
- R2: With `SIGNED_IN=1`, `in_data` is read as two's complement and the product is sign-correct, including for the most negative input.
- R3: With `SIGNED_IN=0`, `in_data` is read as unsigned (zero-extended), including for the all-ones input.
- R4: With the output register present, `out_valid` is high in exactly those cycles that follow an edge at which `in_valid` was high.
- R5: With the output register present, an edge with `in_valid` low leaves `out_product` unchanged, whatever `in_data` carries.
- R6: While `rst_n` is low, and after it is released until the first accepted input, `out_valid` is 0 and `out_product` is 0.
- R7: A coefficient whose run of ones reaches its top bit is recoded with a +1 digit one position above that bit and a -1 at the run's bottom. The product stays exact, for example for COEF = 8'hFF (+2^8 - 2^0).
- R8: With `OUT_REG=0`, `out_valid` equals `in_valid` and `out_product` equals `in_data` times `COEF` in the same cycle, with no clock edge involved.
- R9: The recoded digits of the default coefficient 8'b01101111 are +1 at position 7, -1 at position 4 and -1 at position 0, all others 0. The product of an input of 1 therefore reads 128 - 16 - 1 = 111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word is valid this cycle |
| in_data | input | DATA_W | Multiplicand, unsigned or two's complement per `SIGNED_IN` |
| out_valid | output | 1 | Product is valid |
| out_product | output | DATA_W+COEF_W+1 | Full-width product |

## Verification
On every cycle, the assertions check three things against a plain reference multiply of the registered input: the one-cycle valid alignment, the hold of the product register on idle edges, and the exactness of the product whenever valid is high. In the combinational variant they check the same relations within a single cycle. Only the bench scenarios can show the sign handling at the extreme inputs, the recoding of a coefficient whose ones run reach the top bit, and the specific digit pattern of the default coefficient as seen through unit and power-of-two inputs. The reset values are also shown only by the bench.

// File: rtl/csdm_pkg.sv
package csdm_pkg;

    localparam int MAX_CW = 32;

    typedef logic [MAX_CW:0] digit_mask_t;

    typedef struct packed {
        digit_mask_t plus;
        digit_mask_t minus;
    } csd_code_t;

    // Recode an unsigned coefficient into non-adjacent signed digits.
    // An odd remainder of 3 (mod 4) takes a -1 digit, 1 (mod 4) a +1 digit.
    function automatic csd_code_t csd_recode(input logic [MAX_CW-1:0] coef);
        logic [MAX_CW+1:0] rem;
        csd_code_t code;
        rem = {2'b00, coef};
        code.plus = '0;
        code.minus = '0;
        for (int i = 0; i <= MAX_CW; i++) begin
            if (rem[0]) begin
                if (rem[1]) begin
                    code.minus[i] = 1'b1;
                    rem = rem + 1'b1;
                end else begin
                    code.plus[i] = 1'b1;
                    rem = rem - 1'b1;
                end
            end
            rem = rem >> 1;
        end
        return code;
    endfunction

endpackage

// File: rtl/csdm_term.sv
module csdm_term #(
    parameter int PW    = 17,
    parameter int SHIFT = 0,
    parameter int DIGIT = 0
) (
    input  logic [PW-1:0] ext_in,
    output logic [PW-1:0] term
);
    logic [PW-1:0] shifted;
    assign shifted = ext_in << SHIFT;

    generate
        if (DIGIT > 0) begin : g_plus
            assign term = shifted;
        end else if (DIGIT < 0) begin : g_minus
            assign term = '0 - shifted;
        end else begin : g_zero
            assign term = '0;
            logic unused_bits;
            assign unused_bits = ^shifted;
        end
    endgenerate
endmodule

// File: rtl/csdm_tree.sv
module csdm_tree #(
    parameter int PW = 17,
    parameter int NT = 9
) (
    input  logic [NT*PW-1:0] terms,
    output logic [PW-1:0]    total
);
    localparam int LVLS = (NT > 1) ? $clog2(NT) : 1;
    localparam int NP   = 1 << LVLS;

    logic [PW-1:0] node [1:2*NP-1];

    generate
        for (genvar i = 0; i < NP; i++) begin : g_leaf
            if (i < NT) begin : g_used
                assign node[NP+i] = terms[i*PW +: PW];
            end else begin : g_pad
                assign node[NP+i] = '0;
            end
        end
        for (genvar k = 1; k < NP; k++) begin : g_node
            assign node[k] = node[2*k] + node[2*k+1];
        end
    endgenerate

    assign total = node[1];
endmodule

// File: rtl/csdm_outstage.sv
module csdm_outstage #(
    parameter int PW      = 17,
    parameter bit OUT_REG = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [PW-1:0] sum_in,
    output logic          out_valid,
    output logic [PW-1:0] out_product
);
    typedef enum logic {ST_IDLE = 1'b0, ST_EMIT = 1'b1} ostate_t;

    generate
        if (OUT_REG) begin : g_reg
            ostate_t       state_q, state_d;
            logic [PW-1:0] prod_q;

            always_comb begin
                unique case (state_q)
                    ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
                    ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
                    default: state_d = ST_IDLE;
                endcase
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    state_q <= ST_IDLE;
                end else begin
                    state_q <= state_d;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prod_q <= '0;
                end else if (in_valid) begin
                    prod_q <= sum_in;
                end
            end

            assign out_valid   = (state_q == ST_EMIT);
            assign out_product = prod_q;
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk  = clk ^ rst_n;
            assign out_valid   = in_valid;
            assign out_product = sum_in;
        end
    endgenerate
endmodule

// File: rtl/csdm_mult.sv
module csdm_mult #(
    parameter int                DATA_W    = 8,
    parameter int                COEF_W    = 8,
    parameter logic [COEF_W-1:0] COEF      = 8'b0110_1111,
    parameter bit                SIGNED_IN = 1'b1,
    parameter bit                OUT_REG   = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [DATA_W-1:0]          in_data,
    output logic                       out_valid,
    output logic [DATA_W+COEF_W:0]     out_product
);
    import csdm_pkg::*;

    localparam int PW = DATA_W + COEF_W + 1;
    localparam int ND = COEF_W + 1;
    localparam csd_code_t CODE = csd_recode(MAX_CW'(COEF));

    logic [PW-1:0]    ext_in;
    logic [ND*PW-1:0] terms;
    logic [PW-1:0]    sum;

    generate
        if (SIGNED_IN) begin : g_sext
            assign ext_in = {{(PW-DATA_W){in_data[DATA_W-1]}}, in_data};
        end else begin : g_zext
            assign ext_in = {{(PW-DATA_W){1'b0}}, in_data};
        end

        for (genvar i = 0; i < ND; i++) begin : g_digit
            localparam int DG = CODE.plus[i] ? 1 : (CODE.minus[i] ? -1 : 0);
            csdm_term #(.PW(PW), .SHIFT(i), .DIGIT(DG)) i_term (
                .ext_in (ext_in),
                .term   (terms[i*PW +: PW])
            );
        end
    endgenerate

    csdm_tree #(.PW(PW), .NT(ND)) i_tree (
        .terms (terms),
        .total (sum)
    );

    csdm_outstage #(.PW(PW), .OUT_REG(OUT_REG)) i_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .sum_in      (sum),
        .out_valid   (out_valid),
        .out_product (out_product)
    );
endmodule

// File: rtl/csdm_mult_chk.sv
module csdm_mult_chk #(
    parameter int                DATA_W    = 8,
    parameter int                COEF_W    = 8,
    parameter logic [COEF_W-1:0] COEF      = 8'b0110_1111,
    parameter bit                SIGNED_IN = 1'b1,
    parameter bit                OUT_REG   = 1'b1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [DATA_W-1:0]      in_data,
    input logic                   out_valid,
    input logic [DATA_W+COEF_W:0] out_product
);
    localparam int PW = DATA_W + COEF_W + 1;

    logic [PW-1:0] ref_ext;
    logic [PW-1:0] ref_prod;
    assign ref_ext  = SIGNED_IN ? {{(PW-DATA_W){in_data[DATA_W-1]}}, in_data}
                                : {{(PW-DATA_W){1'b0}}, in_data};
    assign ref_prod = ref_ext * PW'(COEF);

    generate
        if (OUT_REG) begin : g_reg
            a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            a_r4_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
            a_r5_hold_product: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> $stable(out_product));
            a_r1_exact_product: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> (out_product == $past(ref_prod)));
        end else begin : g_comb
            a_r8_comb_valid: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid == in_valid);
            a_r8_comb_product: assert property (@(posedge clk) disable iff (!rst_n)
                out_product == ref_prod);
        end
    endgenerate
endmodule

bind csdm_mult csdm_mult_chk #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .COEF(COEF),
    .SIGNED_IN(SIGNED_IN), .OUT_REG(OUT_REG)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .out_valid   (out_valid),
    .out_product (out_product)
);

// File: tb/test_csdm_mult.sv
module test_csdm_mult;
    localparam int CLK_P = 10;
    localparam int DW    = 8;
    localparam int CW    = 8;
    localparam int PW    = DW + CW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;

    logic          v_s, v_u, v_f, v_c;
    logic [PW-1:0] p_s, p_u, p_f, p_c;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    // signed, default coefficient 111
    csdm_mult i_csdm_mult (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
                           .out_valid(v_s), .out_product(p_s));
    // unsigned, coefficient 111
    csdm_mult #(.SIGNED_IN(1'b0)) i_csdm_mult_u (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
                           .in_data(in_data), .out_valid(v_u), .out_product(p_u));
    // signed, coefficient all ones
    csdm_mult #(.COEF(8'hFF)) i_csdm_mult_f (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
                           .in_data(in_data), .out_valid(v_f), .out_product(p_f));
    // signed, no output register
    csdm_mult #(.OUT_REG(1'b0)) i_csdm_mult_c (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
                           .in_data(in_data), .out_valid(v_c), .out_product(p_c));

    function automatic logic [PW-1:0] exp_s(input logic [DW-1:0] d, input int coef);
        longint v;
        v = longint'($signed(d)) * longint'(coef);
        return PW'(v);
    endfunction

    function automatic logic [PW-1:0] exp_u(input logic [DW-1:0] d, input int coef);
        longint v;
        v = longint'(d) * longint'(coef);
        return PW'(v);
    endfunction

    task automatic chk(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        chk(req, PW'(act), PW'(exp));
    endtask

    // drive one word, then sample one cycle later
    task automatic push_and_check(input logic [DW-1:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        #1;
        chk("R8 comb product", p_c, exp_s(d, 111));
        chk1("R8 comb valid", v_c, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        chk1("R4 valid after accept", v_s, 1'b1);
        chk("R1/R2 signed product", p_s, exp_s(d, 111));
        chk("R3 unsigned product", p_u, exp_u(d, 111));
        chk("R7 all-ones coefficient", p_f, exp_s(d, 255));
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk1("R6 valid in reset", v_s, 1'b0);
        chk("R6 product in reset", p_s, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk1("R6 valid after release", v_s, 1'b0);
        chk("R6 product after release", p_s, '0);
        chk("R6 unsigned product after release", p_u, '0);
    endtask

    task automatic t_digits;
        // R9: digits +2^7 -2^4 -2^0 seen through 1 and powers of two
        push_and_check(8'd1);
        chk("R9 unit input gives 128-16-1", p_s, PW'(111));
        push_and_check(8'd4);
        chk("R9 shifted by two", p_s, PW'(444));
    endtask

    task automatic t_patterns;
        push_and_check(8'd37);
        push_and_check(8'hA5);
        push_and_check(8'h5A);
        push_and_check(8'd0);
    endtask

    task automatic t_extremes;
        push_and_check(8'h80);
        chk("R2 most negative", p_s, PW'(-14208));
        chk("R3 0x80 unsigned", p_u, PW'(14208));
        push_and_check(8'hFF);
        chk("R2 minus one", p_s, PW'(-111));
        chk("R3 all ones unsigned", p_u, PW'(28305));
        chk("R7 all ones times -1", p_f, PW'(-255));
        push_and_check(8'h7F);
        chk("R7 max positive", p_f, PW'(32385));
    endtask

    task automatic t_hold;
        logic [PW-1:0] held;
        push_and_check(8'd19);
        held = p_s;
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 8'd99;
        #1;
        chk1("R8 comb valid low", v_c, 1'b0);
        @(negedge clk);
        chk1("R4 idle edge drops valid", v_s, 1'b0);
        chk("R5 product held", p_s, held);
        chk("R5 unsigned product held", p_u, exp_u(8'd19, 111));
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'd3;
        @(negedge clk);
        chk("R1 burst word 0", p_s, exp_s(8'd3, 111));
        in_data = 8'hF0;
        @(negedge clk);
        chk1("R4 burst valid stays high", v_s, 1'b1);
        chk("R1 burst word 1", p_s, exp_s(8'hF0, 111));
        in_valid = 1'b0;
        @(negedge clk);
        chk1("R4 burst end", v_s, 1'b0);
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_digits();
        t_patterns();
        t_extremes();
        t_hold();
        t_back_to_back();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule